// File: doc/BRIEF.md
# Debounced Status Interrupt Controller

This block gathers status events raised by charger-detection logic and reports them on a single open-drain interrupt pin. Three sources feed it: the raw VBUS comparator level, a charger-type-changed indication and a data-contact-timeout flag. The comparator level is filtered by a debounce window counted in millisecond ticks. Every change of the filtered level is an event. For the other two sources, only a low-to-high change is an event.

Events are held in a sticky pending set. A global enable bit can hide them from the pin without discarding them. A strobe that marks a read of the interrupt status register empties the set. A polarity bit chooses whether the asserted pin is low or high. The pin is modelled as a pull-low enable, because an open-drain output can only pull its line low or release it.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `vbus_stat_o` is 0, no event is pending and `irq_pull_low_o` is 0.
- R2: `vbus_stat_o` takes the value of `vbus_cmp_i` only after the two have differed on `DEB_TICKS` consecutive `ms_tick_i` pulses (default 30). Any clock in which they agree restarts the count. The update happens at the edge that samples the last such tick.
- R3: Every change of `vbus_stat_o`, rising or falling, becomes a pending event. A comparator glitch shorter than the window changes nothing and raises no event.
- R4: A 0-to-1 change of `chg_evt_i` becomes a pending event. A 1-to-0 change does not.
- R5: A 0-to-1 change of `dcd_tmo_i` becomes a pending event. A 1-to-0 change does not.
- R6: The interrupt is asserted one clock after an edge at which `irq_en_i` is 1 and at least one event is pending. When `irq_en_i` is 0, the interrupt is deasserted and pending events are kept.
- R7: An edge with `sts_rd_i` high clears all pending events. An event detected at that same edge stays pending.
- R8: With `irq_pol_i` = 0 the pin is active low (`irq_pull_low_o` = 1 while asserted). With `irq_pol_i` = 1 it is active high (`irq_pull_low_o` = 1 while deasserted).
- R9: Setting `irq_en_i` back to 1 while events are pending asserts the interrupt at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vbus_cmp_i | input | 1 | Raw VBUS comparator level |
| chg_evt_i | input | 1 | Charger-type-changed indication |
| dcd_tmo_i | input | 1 | Data-contact-timeout flag |
| ms_tick_i | input | 1 | One-clock pulse every millisecond |
| irq_en_i | input | 1 | Global interrupt enable |
| irq_pol_i | input | 1 | 0 = active-low pin, 1 = active-high pin |
| sts_rd_i | input | 1 | Status register read strobe, clears pending events |
| vbus_stat_o | output | 1 | Debounced VBUS status |
| irq_pull_low_o | output | 1 | 1 = pull the interrupt line low |

## Verification
The comparator is driven with a long stable high level, then a short glitch, then a long low level. This separates a correct window count from an early update and from a counter that fails to restart. Pulses and held levels on the charger and timeout inputs show that only rising changes create events. Enable, read and polarity are toggled against pending events, including a read that lands in the same clock as a new event, so that masking, clearing and loss on collision can be told apart. A behavioural reference model is compared with both outputs on every clock.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  // Event slots in the pending vector
  localparam int unsigned N_SRC   = 3;
  localparam int unsigned SRC_VB  = 0;
  localparam int unsigned SRC_CHG = 1;
  localparam int unsigned SRC_DCD = 2;
  localparam int unsigned N_RISE  = 2;  // sources that raise an event on 0->1 only
endpackage

// File: rtl/vbus_debounce.sv
module vbus_debounce #(
  parameter int unsigned DEB_TICKS = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic tick_i,
  output logic stat_o,
  output logic flip_o
);
  localparam int unsigned CNT_W = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_TICKS - 1);

  logic             stat_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differ;

  assign differ = raw_i ^ stat_q;
  assign flip_o = differ && tick_i && (cnt_q == LAST);
  assign stat_o = stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        stat_q <= raw_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: the status moves only on a tick
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(stat_q));
  // R2: the status holds while raw agrees with it
  a_r2_hold_on_match: assert property (@(posedge clk) disable iff (rst)
    (raw_i == stat_q) |=> $stable(stat_q));
endmodule

// File: rtl/evt_rise.sv
module evt_rise #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_rise
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic         rd_i,
  input  logic         en_i,
  input  logic         pol_i,
  output logic         pull_low_o
);
  logic [N-1:0] pend_q, pend_d;
  logic         act_d;
  logic         pull_q;

  always_comb begin
    pend_d = (rd_i ? '0 : pend_q) | evt_i;
    act_d  = en_i && (pend_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      pull_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pull_q <= pol_i ? !act_d : act_d;
    end
  end

  assign pull_low_o = pull_q;

  // R7: a read with no new event leaves nothing pending
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_i && (evt_i == '0)) |=> (pend_q == '0));
  // R7: an event colliding with a read survives
  a_r7_collision_kept: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> ((pend_q & $past(evt_i)) == $past(evt_i)));
  // R6: without a read, pending bits are never dropped
  a_r6_pending_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R6/R8: masked means the deasserted pin level
  a_r6_masked_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (pull_low_o == $past(pol_i)));
  // R9: enabled with pending and no read asserts on the next edge
  a_r9_enable_asserts: assert property (@(posedge clk) disable iff (rst)
    (en_i && (pend_q != '0) && !rd_i) |=> (pull_low_o == !$past(pol_i)));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned DEB_TICKS = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic vbus_cmp_i,
  input  logic chg_evt_i,
  input  logic dcd_tmo_i,
  input  logic ms_tick_i,
  input  logic irq_en_i,
  input  logic irq_pol_i,
  input  logic sts_rd_i,
  output logic vbus_stat_o,
  output logic irq_pull_low_o
);
  logic              vb_flip;
  logic [N_RISE-1:0] rise_lvl, rise_evt;
  logic [N_SRC-1:0]  evt;

  vbus_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst(rst), .raw_i(vbus_cmp_i), .tick_i(ms_tick_i),
    .stat_o(vbus_stat_o), .flip_o(vb_flip)
  );

  assign rise_lvl = {dcd_tmo_i, chg_evt_i};

  evt_rise #(.W(N_RISE)) u_rise (
    .clk(clk), .rst(rst), .lvl_i(rise_lvl), .rise_o(rise_evt)
  );

  always_comb begin
    evt          = '0;
    evt[SRC_VB]  = vb_flip;
    evt[SRC_CHG] = rise_evt[0];
    evt[SRC_DCD] = rise_evt[1];
  end

  irq_pending #(.N(N_SRC)) u_pend (
    .clk(clk), .rst(rst), .evt_i(evt), .rd_i(sts_rd_i),
    .en_i(irq_en_i), .pol_i(irq_pol_i), .pull_low_o(irq_pull_low_o)
  );
endmodule

// File: tb/sim_evt_irq_ctrl.sv
module sim_evt_irq_ctrl;
  localparam int DEB = 30;
  localparam int TDIV = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic vbus = 0, chg = 0, dcd = 0, tick = 0, en = 0, pol = 0, rd = 0;
  logic stat_o, pl_o;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // model state
  int m_cnt = 0;
  bit m_stat = 0, m_pc = 0, m_pd = 0, m_pl = 0;
  bit [2:0] m_pend = 0;

  always #10 clk = ~clk;

  evt_irq_ctrl #(.DEB_TICKS(DEB)) u0 (
    .clk(clk), .rst(rst), .vbus_cmp_i(vbus), .chg_evt_i(chg), .dcd_tmo_i(dcd),
    .ms_tick_i(tick), .irq_en_i(en), .irq_pol_i(pol), .sts_rd_i(sts_rd_dummy()),
    .vbus_stat_o(stat_o), .irq_pull_low_o(pl_o)
  );

  function automatic logic sts_rd_dummy();
    return rd;
  endfunction

  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % TDIV) == 0;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference, compared every clock
  always @(posedge clk) begin
    bit flip, act;
    bit [2:0] ev;
    if (rst) begin
      m_cnt = 0; m_stat = 0; m_pc = 0; m_pd = 0; m_pend = 0; m_pl = 0;
    end else begin
      flip = 0;
      if (vbus == m_stat) m_cnt = 0;
      else if (tick) begin
        m_cnt++;
        if (m_cnt == DEB) begin flip = 1; m_stat = vbus; m_cnt = 0; end
      end
      ev = {dcd && !m_pd, chg && !m_pc, flip};
      m_pc = chg; m_pd = dcd;
      m_pend = (rd ? 3'b000 : m_pend) | ev;
      act = en && (m_pend != 0);
      m_pl = pol ? !act : act;
    end
    #5;
    chk(stat_o === m_stat, {cur_req, "/R2 vbus_stat"}, stat_o, m_stat);
    chk(pl_o === m_pl, {cur_req, "/R6 pull_low"}, pl_o, m_pl);
  end

  task automatic after_edge();
    @(posedge clk); #6;
  endtask

  task automatic read_pulse();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    after_edge();
    chk(stat_o === 0, "R1 stat", stat_o, 0);
    chk(pl_o === 0, "R1 pin", pl_o, 0);

    @(negedge clk); en = 1; pol = 0; cur_req = "R2"; vbus = 1;
    repeat (25 * TDIV) @(negedge clk);
    chk(stat_o === 0, "R2 early", stat_o, 0);
    repeat (8 * TDIV) @(negedge clk);
    chk(stat_o === 1, "R2 settled", stat_o, 1);
    chk(pl_o === 1, "R3 rise event", pl_o, 1);
    cur_req = "R7"; read_pulse(); after_edge();
    chk(pl_o === 0, "R7 cleared", pl_o, 0);

    cur_req = "R3";
    @(negedge clk); vbus = 0;
    repeat (2 * TDIV) @(negedge clk); vbus = 1;
    repeat (50 * TDIV) @(negedge clk);
    chk(stat_o === 1, "R3 glitch stat", stat_o, 1);
    chk(pl_o === 0, "R3 glitch no event", pl_o, 0);
    vbus = 0;
    repeat (34 * TDIV) @(negedge clk);
    chk(stat_o === 0, "R3 fall stat", stat_o, 0);
    chk(pl_o === 1, "R3 fall event", pl_o, 1);
    read_pulse();

    cur_req = "R4";
    @(negedge clk); chg = 1;
    after_edge();
    chk(pl_o === 1, "R4 rise", pl_o, 1);
    @(negedge clk); chg = 0; rd = 1;
    @(negedge clk); rd = 0;
    after_edge();
    chk(pl_o === 0, "R4 fall ignored", pl_o, 0);

    cur_req = "R5";
    @(negedge clk); dcd = 1;
    repeat (5) @(negedge clk);
    chk(pl_o === 1, "R5 rise", pl_o, 1);
    read_pulse(); dcd = 0;
    repeat (3) @(negedge clk);
    chk(pl_o === 0, "R5 fall ignored", pl_o, 0);

    cur_req = "R6";
    en = 0; chg = 1;
    @(negedge clk); chg = 0;
    repeat (3) @(negedge clk);
    chk(pl_o === 0, "R6 masked", pl_o, 0);
    cur_req = "R9"; en = 1;
    after_edge();
    chk(pl_o === 1, "R9 reenable", pl_o, 1);
    read_pulse();

    cur_req = "R7";
    @(negedge clk); rd = 1; chg = 1;
    after_edge();
    chk(pl_o === 1, "R7 collision kept", pl_o, 1);
    @(negedge clk); rd = 0; chg = 0;
    read_pulse();

    cur_req = "R8";
    @(negedge clk); pol = 1;
    after_edge();
    chk(pl_o === 1, "R8 idle high-pol", pl_o, 1);
    @(negedge clk); dcd = 1;
    after_edge();
    chk(pl_o === 0, "R8 asserted high-pol", pl_o, 0);
    @(negedge clk); en = 0;
    after_edge();
    chk(pl_o === 1, "R8 masked high-pol", pl_o, 1);
    read_pulse(); dcd = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule